// File: doc/BRIEF.md
# Parallel Port Host Bus Master

This block is the host side of a byte-wide, strobe-and-acknowledge register bus. A local client asks for one register read or one register write through a single-cycle command. The block turns that request into two bus cycles. First comes an address cycle, which writes the register number under the address strobe. Then comes a data cycle under the data strobe, which either drives the write byte out or captures the byte the peripheral returns. When the transfer ends the block raises a one-cycle `done`, or a one-cycle `timeout` if the peripheral stops answering.

Each strobe is interlocked with the peripheral's wait line. The wait line passes through a two-flop synchronizer. A strobe falls only once the synchronized wait is low, and it stays low until the synchronized wait is seen high. A guard counter limits how long the block waits in each setup or strobe phase. The shared data bus is split into `bus_out`, `bus_oe` and `bus_in` so that a pad ring can build the tristate driver. The driver is enabled for the address cycle and for write data cycles, and it is switched off for a whole read data cycle.

Top module: `pph_host_master`

## Requirements
- R1: After a synchronous active-low reset, both strobes are high, `dir_rd`, `bus_oe`, `busy`, `done` and `timeout` are low.
- R2: A command is taken when `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle through the cycle that shows `done` or `timeout`. A command presented while `busy` is high has no effect on the bus or on the peripheral.
- R3: Every command makes exactly one address cycle and then one data cycle. In the address cycle `astb_n` is low and `bus_out` carries `cmd_addr`. In a write data cycle `dstb_n` is low and `bus_out` carries `cmd_wdata`. The two strobes are never low together.
- R4: `dir_rd` is 0 in the address cycle and in a write data cycle, and 1 in a read data cycle. It does not change while a strobe is low, or in the cycle where a strobe falls.
- R5: `bus_oe` is 1 whenever `astb_n` is low or a write data strobe is low, and it is 0 whenever `dstb_n` is low with `dir_rd` at 1.
- R6: If `wait_in` rises `d` clock cycles after a strobe falls, the strobe stays low for `d`+3 cycles. A read data strobe stays low for `d`+4 cycles, because of its extra capture cycle.
- R7: A strobe falls only after `wait_in` has been low at the two preceding falling clock edges, so a new cycle never overlaps the previous one.
- R8: A read loads `rd_data` with the `bus_in` value the peripheral drives during its data cycle. A write and a timed-out access leave `rd_data` unchanged.
- R9: If a setup or strobe phase lasts `tmo_limit` cycles without progress, the block raises the strobe. A limit of 0 acts as 1. A strobe left unanswered therefore stays low for exactly max(`tmo_limit`,1) cycles. `timeout` is then high for one cycle with both strobes high and `done` low, and the block returns to idle.
- R10: A successful access ends with `done` high for exactly one cycle, with both strobes high. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_addr | input | 8 | Register number sent in the address cycle |
| cmd_wdata | input | 8 | Byte sent in a write data cycle |
| tmo_limit | input | 16 | Guard limit in cycles per setup or strobe phase |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse on an abandoned access |
| rd_data | output | 8 | Last byte read |
| astb_n | output | 1 | Address strobe, active low |
| dstb_n | output | 1 | Data strobe, active low |
| dir_rd | output | 1 | Direction: 0 host write, 1 host read |
| wait_in | input | 1 | Peripheral acknowledge, asynchronous |
| bus_in | input | 8 | Bus value seen at the pads |
| bus_out | output | 8 | Bus value driven by the host |
| bus_oe | output | 1 | Host bus driver enable |

## Verification
A wrong sequencer state shows up within one cycle as a strobe pattern that does not fit the expected sequence. Examples are both strobes low, a missing address cycle, or `bus_oe` set during a read data strobe. A fault in the synchronizer or in the acknowledge logic changes the strobe-low length away from `d`+3 or `d`+4, and this is visible on the first access of the sweep over response delays. A guard counter that counts wrongly changes the strobe-low length of a timed-out access, seen at the edge where `timeout` rises. A capture fault shows up as a wrong byte in `rd_data` right after `done`.

// File: rtl/pph_pkg.sv
// Shared types for the parallel port host master.
// Assumes: sequencer and pin decoder agree on these state meanings.
package pph_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for a command
        ST_A_SET,  // address on bus, direction write, wait must be low
        ST_A_STB,  // address strobe low
        ST_A_HLD,  // address strobe high, bus still driven
        ST_D_SET,  // data direction set, wait must be low
        ST_D_STB,  // data strobe low
        ST_D_LAT,  // read only: strobe low, capture bus
        ST_DONE,   // successful end, one cycle
        ST_FAIL    // timed out, one cycle
    } pph_state_e;

    // States in which the guard counter is armed.
    function automatic logic pph_guarded(pph_state_e s);
        return (s == ST_A_SET) || (s == ST_A_STB) ||
               (s == ST_D_SET) || (s == ST_D_STB);
    endfunction

    // States belonging to the address cycle.
    function automatic logic pph_addr_phase(pph_state_e s);
        return (s == ST_A_SET) || (s == ST_A_STB) || (s == ST_A_HLD);
    endfunction

    // States belonging to the data cycle up to its hold.
    function automatic logic pph_data_phase(pph_state_e s);
        return (s == ST_D_SET) || (s == ST_D_STB) ||
               (s == ST_D_LAT) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/pph_wait_sync.sv
// Multi-flop synchronizer for the asynchronous peripheral wait line.
// Assumes: STAGES >= 2; the output is the last flop of the chain.
module pph_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Flop chain, one stage per generate step, cleared by reset.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pph_guard_timer.sv
// Per-phase guard counter. Counts the cycles spent in the current phase
// while armed and flags expiry when the count reaches the limit.
// Assumes: restart is high at the edge where a new phase starts; limit is
// held steady during an access; a limit of 0 behaves like 1.
module pph_guard_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expired
);

    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_plus;

    assign cnt_plus = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};

    // Expiry when this cycle is the limit-th cycle of the phase.
    always_comb begin
        expired = run && (cnt_plus >= {1'b0, limit});
    end

    // Phase cycle counter: cleared on a new phase or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || !run)  cnt <= '0;
        else if (!expired)         cnt <= cnt_plus[CW-1:0];
    end

    // R9: the sequencer leaves an armed phase by the time the limit is hit.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((cnt == '0) || (cnt < limit)));

endmodule

// File: rtl/pph_sequencer.sv
// Access sequencer: takes one command when idle, runs the address cycle
// and the data cycle with wait interlocks, captures read data.
// Assumes: wait_s is already synchronized; expired comes from the guard
// timer for the current phase.
module pph_sequencer
    import pph_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [BUS_W-1:0] cmd_addr,
    input  logic [BUS_W-1:0] cmd_wdata,
    input  logic             wait_s,
    input  logic             expired,
    input  logic [BUS_W-1:0] bus_in,
    output pph_state_e       state,
    output logic             wr_q,
    output logic [BUS_W-1:0] addr_q,
    output logic [BUS_W-1:0] wdata_q,
    output logic [BUS_W-1:0] rd_q,
    output logic             restart,
    output logic             run
);

    pph_state_e state_n;

    // Next-state choice; progress on wait beats expiry in the same cycle.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_n = ST_A_SET;
            ST_A_SET: begin
                if (!wait_s)      state_n = ST_A_STB;
                else if (expired) state_n = ST_FAIL;
            end
            ST_A_STB: begin
                if (wait_s)       state_n = ST_A_HLD;
                else if (expired) state_n = ST_FAIL;
            end
            ST_A_HLD: state_n = ST_D_SET;
            ST_D_SET: begin
                if (!wait_s)      state_n = ST_D_STB;
                else if (expired) state_n = ST_FAIL;
            end
            ST_D_STB: begin
                if (wait_s)       state_n = wr_q ? ST_DONE : ST_D_LAT;
                else if (expired) state_n = ST_FAIL;
            end
            ST_D_LAT: state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            ST_FAIL:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Guard control: a new phase restarts the count; only waiting phases arm it.
    always_comb begin
        restart = (state_n != state);
        run     = pph_guarded(state);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Command capture, only in idle so commands seen while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if ((state == ST_IDLE) && cmd_valid) begin
            wr_q    <= cmd_write;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    // Read data capture in the cycle after the acknowledge was seen.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_q <= '0;
        else if (state == ST_D_LAT) rd_q <= bus_in;
    end

    // R2: the captured command does not move once an access is under way.
    p_cmd_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));

    // R8: read data only changes in a read capture cycle.
    p_rd_only_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_q) |-> ($past(state) == ST_D_LAT));

endmodule

// File: rtl/pph_pin_drive.sv
// Pin decoder: derives strobes, direction, bus driver and status pulses
// from the sequencer state register and the captured command.
// Assumes: outputs change only with the state register, so no glitches
// reach the pads beyond the flop-to-pad path.
module pph_pin_drive
    import pph_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  pph_state_e       state,
    input  logic             wr_q,
    input  logic [BUS_W-1:0] addr_q,
    input  logic [BUS_W-1:0] wdata_q,
    output logic             astb_n,
    output logic             dstb_n,
    output logic             dir_rd,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_out,
    output logic             busy,
    output logic             done,
    output logic             timeout
);

    // Strobe decode: address strobe in one state, data strobe in two.
    always_comb begin
        astb_n = (state != ST_A_STB);
        dstb_n = !((state == ST_D_STB) || (state == ST_D_LAT));
    end

    // Direction and driver: the address cycle is always a host write.
    always_comb begin
        dir_rd = !wr_q && (state == ST_D_SET || state == ST_D_STB || state == ST_D_LAT);
        bus_oe = pph_addr_phase(state) || (wr_q && pph_data_phase(state));
    end

    // Bus value: register number in the address cycle, write byte after.
    always_comb begin
        if (pph_addr_phase(state))              bus_out = addr_q;
        else if (wr_q && pph_data_phase(state)) bus_out = wdata_q;
        else                                    bus_out = '0;
    end

    // Status decode.
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        timeout = (state == ST_FAIL);
    end

endmodule

// File: rtl/pph_host_master.sv
// Top of the parallel port host master. Wires the wait synchronizer, the
// guard timer, the sequencer and the pin decoder.
// Assumes: bus_in reflects the pads; a pad ring builds the tristate from
// bus_out and bus_oe; tmo_limit is steady while busy.
module pph_host_master
    import pph_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [BUS_W-1:0] cmd_addr,
    input  logic [BUS_W-1:0] cmd_wdata,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             done,
    output logic             timeout,
    output logic [BUS_W-1:0] rd_data,
    output logic             astb_n,
    output logic             dstb_n,
    output logic             dir_rd,
    input  logic             wait_in,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);

    pph_state_e       state;
    logic             wait_s;
    logic             expired;
    logic             restart;
    logic             run;
    logic             wr_q;
    logic [BUS_W-1:0] addr_q;
    logic [BUS_W-1:0] wdata_q;

    pph_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wait_in),
        .sync_out (wait_s)
    );

    pph_guard_timer #(.CW(TMO_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .limit   (tmo_limit),
        .expired (expired)
    );

    pph_sequencer #(.BUS_W(BUS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .wait_s    (wait_s),
        .expired   (expired),
        .bus_in    (bus_in),
        .state     (state),
        .wr_q      (wr_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rd_q      (rd_data),
        .restart   (restart),
        .run       (run)
    );

    pph_pin_drive #(.BUS_W(BUS_W)) u_pins (
        .state   (state),
        .wr_q    (wr_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .astb_n  (astb_n),
        .dstb_n  (dstb_n),
        .dir_rd  (dir_rd),
        .bus_oe  (bus_oe),
        .bus_out (bus_out),
        .busy    (busy),
        .done    (done),
        .timeout (timeout)
    );

    // R4: direction is settled before and during any strobe.
    p_dir_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!astb_n || !dstb_n) |-> $stable(dir_rd));

    // R5: no host drive while the peripheral owns the bus.
    p_no_contend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dstb_n && dir_rd) |-> !bus_oe);

    // R6: a completed address strobe was released only after acknowledge.
    p_release_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(astb_n) && !timeout) |-> $past(wait_s));

    // R7: a strobe never starts while the previous cycle is acknowledged.
    p_start_idle_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(astb_n) || $fell(dstb_n)) |-> !$past(wait_s));

    // R10: the completion pulse is followed by an idle cycle.
    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |=> (!busy && astb_n && dstb_n));

endmodule

// File: tb/pph_host_master_tb.sv
module pph_host_master_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_addr = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic [15:0] tmo_limit = 16'd100;
    logic       busy, done, timeout;
    logic [7:0] rd_data;
    logic       astb_n, dstb_n, dir_rd, bus_oe;
    logic       wait_in = 1'b0;
    logic [7:0] bus_in;
    logic [7:0] bus_out;

    always #5 clk = ~clk;

    pph_host_master u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .timeout(timeout), .rd_data(rd_data),
        .astb_n(astb_n), .dstb_n(dstb_n), .dir_rd(dir_rd), .wait_in(wait_in),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    // Peripheral model state.
    logic [7:0] mem [256];
    logic [7:0] last_addr = 8'h00;
    int  resp_dly = 0, rel_dly = 0, p_mode = 0;
    int  p_cnt = 0, r_cnt = 0;
    int  n_addr = 0, n_wr = 0;
    int  a_cur = 0, a_last = 0, d_cur = 0, d_last = 0;
    int  v_both = 0, v_contend = 0, v_dir = 0, v_start = 0, v_oe = 0;
    int  n_chk = 0, n_fail = 0;
    logic prev_any_low = 1'b0, prev_dir = 1'b0, h1 = 1'b0;

    assign bus_in = (!dstb_n && dir_rd) ? mem[last_addr] : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Peripheral model and protocol monitor, acting on falling edges.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!astb_n && !dstb_n) v_both++;
                if (!dstb_n && dir_rd && bus_oe) v_contend++;
                if ((!astb_n || !dstb_n) && prev_any_low && (dir_rd != prev_dir)) v_dir++;
                if ((!astb_n || !dstb_n) && !prev_any_low && (wait_in || h1)) v_start++;
                if (!astb_n) a_cur++; else if (a_cur != 0) begin a_last = a_cur; a_cur = 0; end
                if (!dstb_n) d_cur++; else if (d_cur != 0) begin d_last = d_cur; d_cur = 0; end
                h1 = wait_in;
                prev_any_low = !astb_n || !dstb_n;
                prev_dir = dir_rd;
                if (!astb_n || !dstb_n) begin
                    r_cnt = 0;
                    if (!wait_in && (p_mode == 0 || (p_mode == 2 && !astb_n))) begin
                        if (p_cnt >= resp_dly) begin
                            wait_in = 1'b1;
                            if (!astb_n) begin
                                last_addr = bus_out; n_addr++;
                                if (dir_rd || !bus_oe) v_oe++;
                            end else if (!dir_rd) begin
                                mem[last_addr] = bus_out; n_wr++;
                                if (!bus_oe) v_oe++;
                            end
                        end else p_cnt++;
                    end
                end else begin
                    p_cnt = 0;
                    if (wait_in) begin
                        if (r_cnt >= rel_dly) wait_in = 1'b0; else r_cnt++;
                    end
                end
            end
        end
    end

    // Issue one command and wait for its end; optional flood while busy.
    task automatic do_cmd(input bit wr, input logic [7:0] a, input logic [7:0] dat,
                          input bit flood, output bit got_done, output bit got_tmo,
                          output bit idle_strobes);
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = dat;
        @(negedge clk); #1;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (flood) begin
            cmd_write = 1'b1; cmd_addr = 8'hEE; cmd_wdata = 8'h5A;
        end else cmd_valid = 1'b0;
        for (int i = 0; i < 400 && !(done || timeout); i++) begin
            @(negedge clk); #1;
        end
        got_done = done; got_tmo = timeout;
        idle_strobes = astb_n && dstb_n;
        cmd_valid = 1'b0;
        @(negedge clk); #1;
        chk(!busy && !done && !timeout, "R10 single end pulse then idle",
            {busy, done, timeout}, 0);
    endtask

    initial begin
        bit gd, gt, ids;
        int na, nw, exp_len;
        logic [7:0] ad, wd, pre;

        repeat (3) @(negedge clk);
        #1;
        chk(astb_n && dstb_n && !dir_rd && !bus_oe && !busy && !done && !timeout,
            "R1 reset state", {astb_n, dstb_n, dir_rd, bus_oe, busy, done, timeout}, 7'b1100000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(astb_n && dstb_n && !busy, "R1 idle after reset", {astb_n, dstb_n, busy}, 3'b110);

        // Sweep response delay, release delay and address.
        for (int d = 0; d < 4; d++) begin
            for (int r = 0; r < 3; r++) begin
                for (int ai = 0; ai < 4; ai++) begin
                    resp_dly = d; rel_dly = r; p_mode = 0; tmo_limit = 16'd100;
                    ad = 8'((ai * 85 + d * 5 + r) & 255);
                    wd = 8'((ad * 3 + d * 17 + r * 41 + 1) & 255);
                    pre = rd_data; nw = n_wr; na = n_addr;
                    do_cmd(1'b1, ad, wd, 1'b0, gd, gt, ids);
                    chk(gd && !gt && ids, "R10 write done with strobes high", {gd, gt, ids}, 3'b101);
                    chk(rd_data == pre, "R8 write keeps rd_data", rd_data, pre);
                    chk(a_last == d + 3, "R6 address strobe length", a_last, d + 3);
                    chk(d_last == d + 3, "R6 write strobe length", d_last, d + 3);
                    chk(last_addr == ad, "R3 address cycle value", last_addr, ad);
                    chk(mem[ad] == wd, "R3 write data value", mem[ad], wd);
                    chk(n_wr == nw + 1 && n_addr == na + 1, "R3 one address and one data cycle",
                        n_wr - nw, 1);
                    do_cmd(1'b0, ad, 8'h00, 1'b0, gd, gt, ids);
                    chk(gd && !gt, "R10 read done", {gd, gt}, 2'b10);
                    chk(rd_data == wd, "R8 read data", rd_data, wd);
                    chk(d_last == d + 4, "R6 read strobe length", d_last, d + 4);
                    chk(n_wr == nw + 1, "R4 read cycle is not a write", n_wr - nw, 1);
                end
            end
        end

        // Commands presented while busy are ignored.
        resp_dly = 1; rel_dly = 1; na = n_addr;
        do_cmd(1'b1, 8'h21, 8'h77, 1'b1, gd, gt, ids);
        chk(mem[8'hEE] == (8'hEE ^ 8'hA5), "R2 flood command ignored", mem[8'hEE], 8'hEE ^ 8'hA5);
        chk(n_addr == na + 1, "R2 only one address cycle", n_addr - na, 1);
        chk(mem[8'h21] == 8'h77, "R2 accepted command done", mem[8'h21], 8'h77);
        repeat (4) @(negedge clk);
        #1;
        chk(!busy && n_addr == na + 1, "R2 nothing started after flood", n_addr - na, 1);

        // Silent peripheral: timeout on the address strobe.
        for (int k = 0; k < 5; k++) begin
            int lim;
            lim = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 9;
            p_mode = 1; tmo_limit = 16'(lim); na = n_addr; pre = rd_data;
            exp_len = (lim == 0) ? 1 : lim;
            do_cmd(1'b0, 8'h33, 8'h00, 1'b0, gd, gt, ids);
            chk(gt && !gd && ids, "R9 timeout pulse with strobes high", {gt, gd, ids}, 3'b101);
            chk(a_last == exp_len, "R9 unanswered strobe length", a_last, exp_len);
            chk(rd_data == pre, "R8 timeout keeps rd_data", rd_data, pre);
        end

        // Peripheral answers the address cycle only: timeout on data strobe.
        p_mode = 2; resp_dly = 0; rel_dly = 0; tmo_limit = 16'd6; nw = n_wr;
        do_cmd(1'b1, 8'h44, 8'h99, 1'b0, gd, gt, ids);
        chk(gt && !gd, "R9 data strobe timeout", {gt, gd}, 2'b10);
        chk(a_last == 3, "R6 address strobe before data timeout", a_last, 3);
        chk(d_last == 6, "R9 data strobe length", d_last, 6);
        chk(n_wr == nw, "R9 no data written", n_wr - nw, 0);

        // Recovery after timeouts.
        p_mode = 0; tmo_limit = 16'd100;
        do_cmd(1'b0, 8'h21, 8'h00, 1'b0, gd, gt, ids);
        chk(gd && rd_data == 8'h77, "R9 recovery read", rd_data, 8'h77);

        chk(v_both == 0, "R3 strobes never both low", v_both, 0);
        chk(v_dir == 0, "R4 direction steady under strobe", v_dir, 0);
        chk(v_contend == 0 && v_oe == 0, "R5 driver enable rules", v_contend + v_oe, 0);
        chk(v_start == 0, "R7 strobe start after wait low", v_start, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule